// File: doc/BRIEF.md
# Accumulator ALU with Four Status Flags

This block is the arithmetic and logic core of a small accumulator-based processor. Each cycle it takes the accumulator, a second operand, an operation code and the incoming carry flag. It forms the 8-bit result combinationally. It also holds a registered status byte with four flags: zero, subtract, half-carry and carry. A four-bit write mask leaves the block beside the result, so the surrounding register file knows which flags the current operation changes.

Two 16-bit modes sit beside the 8-bit operations. One adds two register pairs and the other increments a register pair. Both drive a separate 16-bit result, and neither may touch any flag.

The status byte changes only on a clock edge where `op_valid` is high, and only in the positions that the write mask enables. Register storage and memory operands belong to the surrounding datapath.

Top module: `alu8_flags`

## Requirements
- R1: Operation codes are ADD=0 and ADC=1. These give `result = acc + opnd (+ carry_in for ADC)` modulo 256. After the edge, C holds the carry out of bit 7.
- R2: Operation codes are SUB=2 and SBC=3. These give `result = acc - opnd (- carry_in for SBC)` modulo 256. After the edge, C is 1 when the true difference is negative (a borrow).
- R3: H is the half-carry flag. For additions, H is 1 when the low nibbles plus carry-in exceed 0xF. For subtractions, H is 1 when the low nibble needs a borrow from bit 4.
- R4: Z is the zero flag. Every operation that writes Z sets it to 1 exactly when the 8-bit result is 0x00.
- R5: N is the subtract flag. It is set by SUB, SBC and DEC, and cleared by every other operation that writes it.
- R6: Operation codes are AND=4, OR=5 and XOR=6, and each combines `opnd` with `acc`. AND sets H and clears N and C. OR and XOR clear N, H and C.
- R7: Operation codes are INC=7 and DEC=8. These give `result = opnd + 1` and `opnd - 1`, and `acc` is not used. They write Z, N and H, so `flag_we = 4'b1110`. C keeps its previous value.
- R8: Operation codes are ADD16=9 and INC16=10. These give `wide_result = pair_a + pair_b` or `pair_a + 1`, modulo 65536. `flag_we` is 0 and the status byte is unchanged.
- R9: The status byte is `{Z,N,H,C,4'b0000}`, with Z at bit 7 and C at bit 4. Bits 3..0 always read 0. Reset sets the byte to 0x00.
- R10: `flag_we` bit order is `{Z,N,H,C}`. With `op_valid` low the status byte holds. Codes 11 to 15 write no flags, and for those codes and the 16-bit codes `result` equals `acc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation is issued this cycle; allows the status byte to update |
| op_code | input | 4 | Operation select |
| acc | input | 8 | Accumulator operand |
| opnd | input | 8 | Second operand, or the value for INC/DEC |
| carry_in | input | 1 | Incoming carry flag for ADC/SBC |
| pair_a | input | 16 | First register pair for the 16-bit modes |
| pair_b | input | 16 | Second register pair for ADD16 |
| result | output | 8 | Combinational 8-bit result |
| wide_result | output | 16 | Combinational 16-bit result |
| flag_we | output | 4 | Flags written by this operation, {Z,N,H,C} |
| flags_q | output | 8 | Registered status byte {Z,N,H,C,0000} |

## Verification
The bound checker watches these properties on every cycle:
- the low four bits of the status byte stay zero;
- the status byte holds when nothing is issued or when a 16-bit mode runs;
- INC and DEC keep the carry;
- the zero flag follows the previous result;
- N follows whether the operation was a subtraction;
- AND always leaves H set and C clear.

Only the bench's scenarios can show the arithmetic values and the exact carry and half-carry boundaries. Those cover 0x0F+1, 0xFF+1, 0x10-1, borrows that wrap through zero, and ADC/SBC with the carry input both set and clear. They are checked against a model built from the requirements.

// File: rtl/alu8_pkg.sv
// Package: shared operation codes and flag positions for the accumulator ALU.
// Assumes a 4-bit operation code and four flags packed in the top nibble.
package alu8_pkg;
    localparam int OP_W      = 4;
    localparam int NUM_FLAGS = 4;

    localparam logic [OP_W-1:0] OP_ADD   = 4'd0;
    localparam logic [OP_W-1:0] OP_ADC   = 4'd1;
    localparam logic [OP_W-1:0] OP_SUB   = 4'd2;
    localparam logic [OP_W-1:0] OP_SBC   = 4'd3;
    localparam logic [OP_W-1:0] OP_AND   = 4'd4;
    localparam logic [OP_W-1:0] OP_OR    = 4'd5;
    localparam logic [OP_W-1:0] OP_XOR   = 4'd6;
    localparam logic [OP_W-1:0] OP_INC   = 4'd7;
    localparam logic [OP_W-1:0] OP_DEC   = 4'd8;
    localparam logic [OP_W-1:0] OP_ADD16 = 4'd9;
    localparam logic [OP_W-1:0] OP_INC16 = 4'd10;

    // Index of each flag within the 4-bit flag vector {Z,N,H,C}.
    localparam int FI_Z = 3;
    localparam int FI_N = 2;
    localparam int FI_H = 1;
    localparam int FI_C = 0;

    // Logic unit selector.
    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2
    } logic_sel_e;
endpackage

// File: rtl/alu8_arith.sv
// Module: add/subtract unit with carry-in, carry/borrow out and half-carry.
// Assumes W is even; the half-carry is taken at the nibble boundary W/2.
module alu8_arith #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         cout,
    output logic         hout
);
    localparam int NIB = W / 2;

    logic [W:0]   full;
    logic [NIB:0] low;

    // Full-width and low-nibble sum or difference; the top bit is carry or borrow.
    always_comb begin
        if (sub) begin
            full = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
            low  = {1'b0, a[NIB-1:0]} - {1'b0, b[NIB-1:0]} - {{NIB{1'b0}}, cin};
        end else begin
            full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
            low  = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, cin};
        end
    end

    assign res  = full[W-1:0];
    assign cout = full[W];
    assign hout = low[NIB];
endmodule

// File: rtl/alu8_logic.sv
// Module: bitwise AND/OR/XOR unit.
// Assumes the selector is one of the three logic codes; any other value gives AND.
module alu8_logic #(
    parameter int W = 8
) (
    input  logic [W-1:0]          a,
    input  logic [W-1:0]          b,
    input  alu8_pkg::logic_sel_e  sel,
    output logic [W-1:0]          res
);
    import alu8_pkg::*;

    // Pick the requested bitwise combination.
    always_comb begin
        unique case (sel)
            LG_OR:   res = a | b;
            LG_XOR:  res = a ^ b;
            default: res = a & b;
        endcase
    end
endmodule

// File: rtl/alu8_wide.sv
// Module: register-pair adder used by the flag-neutral 16-bit modes.
// Assumes wrap-around modulo 2**W; produces no flags.
module alu8_wide #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         inc,
    output logic [W-1:0] res
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    // Add the second pair or the constant one.
    always_comb begin
        res = a + (inc ? ONE : b);
    end
endmodule

// File: rtl/alu8_flagreg.sv
// Module: status register with per-flag write enables.
// Assumes flags occupy the top NF bits of a W-bit byte; the remaining low bits read 0.
module alu8_flagreg #(
    parameter int W  = 8,
    parameter int NF = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd,
    input  logic [NF-1:0] we,
    input  logic [NF-1:0] nxt,
    output logic [W-1:0]  flags
);
    localparam int LOW = W - NF;

    logic [NF-1:0] bits_q;

    for (genvar i = 0; i < NF; i++) begin : g_flag
        // Hold or load one flag bit.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bits_q[i] <= 1'b0;
            else if (upd && we[i])
                bits_q[i] <= nxt[i];
        end
    end

    assign flags = {bits_q, {LOW{1'b0}}};
endmodule

// File: rtl/alu8_flags.sv
// Module: top of the accumulator ALU: decodes the operation, selects the unit
// result, forms the new flags and write mask, and keeps the status byte.
// Assumes W is even and the status byte is W bits wide.
module alu8_flags #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           op_valid,
    input  logic [3:0]     op_code,
    input  logic [W-1:0]   acc,
    input  logic [W-1:0]   opnd,
    input  logic           carry_in,
    input  logic [2*W-1:0] pair_a,
    input  logic [2*W-1:0] pair_b,
    output logic [W-1:0]   result,
    output logic [2*W-1:0] wide_result,
    output logic [3:0]     flag_we,
    output logic [W-1:0]   flags_q
);
    import alu8_pkg::*;

    localparam int WW = 2 * W;
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic               is_arith, is_step, is_sub, use_cin, is_logic, is_and;
    logic [W-1:0]       ar_a, ar_b, ar_res, lg_res;
    logic               ar_c, ar_h;
    logic_sel_e         lg_sel;
    logic [NUM_FLAGS-1:0] nf;

    // Decode operation classes.
    always_comb begin
        is_step  = (op_code == OP_INC) || (op_code == OP_DEC);
        is_arith = (op_code <= OP_SBC) || is_step;
        is_sub   = (op_code == OP_SUB) || (op_code == OP_SBC) || (op_code == OP_DEC);
        use_cin  = (op_code == OP_ADC) || (op_code == OP_SBC);
        is_logic = (op_code == OP_AND) || (op_code == OP_OR) || (op_code == OP_XOR);
        is_and   = (op_code == OP_AND);
        unique case (op_code)
            OP_OR:   lg_sel = LG_OR;
            OP_XOR:  lg_sel = LG_XOR;
            default: lg_sel = LG_AND;
        endcase
    end

    // Steer operands: INC/DEC act on opnd with a constant one.
    always_comb begin
        ar_a = is_step ? opnd : acc;
        ar_b = is_step ? ONE  : opnd;
    end

    alu8_arith #(.W(W)) u_arith (
        .a    (ar_a),
        .b    (ar_b),
        .cin  (use_cin & carry_in),
        .sub  (is_sub),
        .res  (ar_res),
        .cout (ar_c),
        .hout (ar_h)
    );

    alu8_logic #(.W(W)) u_logic (
        .a   (acc),
        .b   (opnd),
        .sel (lg_sel),
        .res (lg_res)
    );

    alu8_wide #(.W(WW)) u_wide (
        .a   (pair_a),
        .b   (pair_b),
        .inc (op_code == OP_INC16),
        .res (wide_result)
    );

    // Select the 8-bit result; non-8-bit codes pass the accumulator.
    always_comb begin
        if (is_arith)
            result = ar_res;
        else if (is_logic)
            result = lg_res;
        else
            result = acc;
    end

    // Form the new flag values and the write mask.
    always_comb begin
        nf        = '0;
        nf[FI_Z]  = (result == '0);
        nf[FI_N]  = is_arith & is_sub;
        nf[FI_H]  = is_arith ? ar_h : is_and;
        nf[FI_C]  = is_arith & ar_c;
        if (is_step)
            flag_we = 4'b1110;
        else if (is_arith || is_logic)
            flag_we = 4'b1111;
        else
            flag_we = 4'b0000;
    end

    alu8_flagreg #(.W(W), .NF(NUM_FLAGS)) u_freg (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (op_valid),
        .we    (flag_we),
        .nxt   (nf),
        .flags (flags_q)
    );
endmodule

// File: rtl/alu8_flags_chk.sv
// Module: property checker for the accumulator ALU, bound to the top.
// Assumes the default 8-bit width and the package operation codes.
module alu8_flags_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       op_valid,
    input logic [3:0] op_code,
    input logic [7:0] result,
    input logic [3:0] flag_we,
    input logic [7:0] flags_q
);
    import alu8_pkg::*;

    logic wide_op, sub_op, step_op, eightbit_op;
    assign wide_op     = (op_code == OP_ADD16) || (op_code == OP_INC16);
    assign sub_op      = (op_code == OP_SUB) || (op_code == OP_SBC) || (op_code == OP_DEC);
    assign step_op     = (op_code == OP_INC) || (op_code == OP_DEC);
    assign eightbit_op = (op_code <= OP_DEC);

    assert_low_nibble_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flags_q[3:0] == 4'h0);

    assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(flags_q));

    assert_wide_no_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && wide_op) |=> $stable(flags_q));

    assert_wide_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wide_op |-> flag_we == 4'b0000);

    assert_step_keeps_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && step_op) |=> flags_q[4] == $past(flags_q[4]));

    assert_zero_tracks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && eightbit_op) |=> flags_q[7] == ($past(result) == 8'h00));

    assert_sub_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && eightbit_op) |=> flags_q[6] == $past(sub_op));

    assert_and_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_AND) |=> (flags_q[5] && !flags_q[4]));
endmodule

bind alu8_flags alu8_flags_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .result   (result),
    .flag_we  (flag_we),
    .flags_q  (flags_q)
);

// File: tb/alu8_flags_tb.sv
// Scoreboard bench: the driver issues operations and queues expected items;
// the monitor pops one per cycle after the clock edge and compares.
`timescale 1ns/1ps
module alu8_flags_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [7:0]  acc = '0, opnd = '0;
    logic        carry_in = 1'b0;
    logic [15:0] pair_a = '0, pair_b = '0;
    logic [7:0]  result;
    logic [15:0] wide_result;
    logic [3:0]  flag_we;
    logic [7:0]  flags_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [7:0] model_fl = 8'h00;

    typedef struct {
        string       tag;
        logic [7:0]  res;
        logic [3:0]  we;
        logic [7:0]  fl;
        logic [15:0] wide;
        bit          chk_wide;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    alu8_flags u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .acc(acc), .opnd(opnd), .carry_in(carry_in), .pair_a(pair_a),
        .pair_b(pair_b), .result(result), .wide_result(wide_result),
        .flag_we(flag_we), .flags_q(flags_q)
    );

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Reference model built from the requirements.
    task automatic model(input logic [3:0] op, input int a, input int b, input int cin,
                         input int pa, input int pb,
                         output logic [7:0] res, output logic [3:0] we,
                         output logic [3:0] nf, output logic [15:0] wide);
        int s, ci;
        bit z, n, h, c;
        n = 0; h = 0; c = 0; wide = 16'h0; we = 4'b1111;
        ci = (op == 1 || op == 3) ? cin : 0;
        case (op)
            0, 1: begin s = a + b + ci; h = ((a & 15) + (b & 15) + ci) > 15; c = s > 255; end
            2, 3: begin s = a - b - ci; n = 1; h = (a & 15) < ((b & 15) + ci); c = a < (b + ci); end
            4: begin s = a & b; h = 1; end
            5: s = a | b;
            6: s = a ^ b;
            7: begin s = b + 1; h = (b & 15) == 15; we = 4'b1110; end
            8: begin s = b - 1; n = 1; h = (b & 15) == 0; we = 4'b1110; end
            9: begin s = a; wide = 16'(pa + pb); we = 4'b0000; end
            10: begin s = a; wide = 16'(pa + 1); we = 4'b0000; end
            default: begin s = a; we = 4'b0000; end
        endcase
        res = 8'(s & 255);
        z = (res == 8'h00);
        nf = {z, n, h, c};
    endtask

    // Driver: apply one operation at the falling edge and queue its expectation.
    task automatic drive(input string tag, input bit v, input logic [3:0] op,
                         input logic [7:0] a, input logic [7:0] b, input bit cin,
                         input logic [15:0] pa, input logic [15:0] pb);
        exp_t e;
        logic [3:0] nf;
        @(negedge clk);
        op_valid = v; op_code = op; acc = a; opnd = b; carry_in = cin;
        pair_a = pa; pair_b = pb;
        model(op, a, b, cin, pa, pb, e.res, e.we, nf, e.wide);
        if (v) begin
            for (int i = 0; i < 4; i++)
                if (e.we[i]) model_fl[4+i] = nf[i];
        end
        e.tag = tag; e.fl = model_fl; e.chk_wide = (op == 9 || op == 10);
        sb.push_back(e);
    endtask

    // Monitor: one expected item per cycle, compared just after the rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                cmp(e.tag, "result", int'(result), int'(e.res));
                cmp(e.tag, "flag_we", int'(flag_we), int'(e.we));
                cmp(e.tag, "flags", int'(flags_q), int'(e.fl));
                if (e.chk_wide) cmp(e.tag, "wide", int'(wide_result), int'(e.wide));
            end
        end
    end

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 cmp("R9", "reset flags", int'(flags_q), 0);
        @(negedge clk) rst_n = 1'b1;
        // R1 / R3: nibble carry, full carry, add with carry
        drive("R1", 1, 0, 8'h0F, 8'h01, 0, 0, 0);
        drive("R1", 1, 0, 8'hFF, 8'h01, 0, 0, 0);
        drive("R1", 1, 1, 8'h0E, 8'h01, 1, 0, 0);
        drive("R1", 1, 1, 8'h7F, 8'h80, 0, 0, 0);
        // R2 / R3 / R5: borrows
        drive("R2", 1, 2, 8'h10, 8'h01, 0, 0, 0);
        drive("R2", 1, 2, 8'h01, 8'h02, 0, 0, 0);
        drive("R2", 1, 3, 8'h05, 8'h04, 1, 0, 0);
        drive("R2", 1, 3, 8'h00, 8'h00, 1, 0, 0);
        drive("R4", 1, 2, 8'h42, 8'h42, 0, 0, 0);
        // R6: logic operations
        drive("R6", 1, 4, 8'hF0, 8'h0F, 1, 0, 0);
        drive("R6", 1, 5, 8'h00, 8'h00, 0, 0, 0);
        drive("R6", 1, 6, 8'hA5, 8'h5A, 0, 0, 0);
        // R7: set carry first, then INC/DEC must keep it
        drive("R7", 1, 0, 8'hFF, 8'h02, 0, 0, 0);
        drive("R7", 1, 7, 8'h00, 8'hFF, 0, 0, 0);
        drive("R7", 1, 8, 8'h33, 8'h01, 0, 0, 0);
        drive("R7", 1, 8, 8'h33, 8'h10, 0, 0, 0);
        // R8: wide modes leave flags alone
        drive("R8", 1, 9, 8'h12, 8'h00, 0, 16'hFFFF, 16'h0002);
        drive("R8", 1, 10, 8'h34, 8'h00, 0, 16'h00FF, 16'h0000);
        // R10: idle and unused codes
        drive("R10", 0, 2, 8'h00, 8'h01, 0, 0, 0);
        drive("R10", 1, 13, 8'h9C, 8'h01, 1, 0, 0);
        // R5 / R9: mixed stream
        for (int i = 0; i < 300; i++)
            drive("R5", 1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)),
                  8'($urandom), 8'($urandom), 1'($urandom),
                  16'($urandom), 16'($urandom));
        @(negedge clk) op_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        done = 1'b1;
        summary();
        $finish;
    end
endmodule